// File: doc/BRIEF.md
# Serial Complex Sync-Sequence Correlator

This block looks for a known complex synchronization sequence in a slow stream of complex samples. It works as a 64-tap correlator on a fast system clock. Each input sample gets a 64-cycle slot. In that slot one complex multiply-accumulate unit visits every tap once, newest sample first. At the end of the slot the block reports one correlation magnitude. A parallel array of 64 complex multipliers is not needed, because the system clock runs 64 times faster than the sample rate.

The delay line is a 64-entry circular buffer. The coefficients come from a fixed table of 64 complex values, stored already conjugated. Two build-time choices change the datapath. The first is the sample format: signed multi-bit, or 1-bit sign values taken from a comparator-type converter. In the 1-bit format every product becomes an add or subtract of coefficient parts. The second is the magnitude form: squared, or the cheaper sum of absolute values.

Control is a two-state machine. In S_IDLE the block waits. The transition T_ACCEPT fires on a valid sample: the sample is written into the buffer and tap 0 is processed in that same cycle. In S_RUN the transition T_STEP processes taps 1 to 62. The transition T_FINISH processes tap 63, registers the magnitude and returns to S_IDLE. T_IDLE_HOLD keeps S_IDLE while no sample arrives. A sample that arrives in S_RUN is dropped and sets a sticky overrun flag.

Top module: `corr_serial_mf`

## Requirements
- R1: While reset is low, and in the first cycle after reset, corr_valid, overrun and corr_mag are all zero.
- R2: For each accepted sample n, the block computes y = sum over k = 0..63 of x[n-k]·c[k], using complex products. The coefficient c[k] has real part ((5k+3) mod 15) − 7 and imaginary part ((11k+6) mod 15) − 7. Here x[n] is the newest accepted sample.
- R3: corr_valid is high for exactly one cycle. That cycle comes 64 cycles after the cycle in which the sample was accepted.
- R4: With ONE_BIT = 0, smp_i and smp_q are read as 10-bit two's-complement values. History from before the first accepted sample counts as 0.
- R5: With ONE_BIT = 1, only bit 0 of each input is used: 0 means +1 and 1 means −1. The other bits have no effect. History from before the first accepted sample counts as +1.
- R6: With MAG_SQ = 1, corr_mag is re² + im² of y. With MAG_SQ = 0, it is |re| + |im|.
- R7: Samples that arrive exactly 64 cycles apart are all accepted. The result of one sample appears in the same cycle in which the next sample is accepted.
- R8: smp_valid in any of the 63 cycles that follow an acceptance sets overrun in the next cycle. That sample is dropped: it never enters the delay line and does not change any later result.
- R9: Once set, overrun stays high until reset.
- R10: Each accepted sample produces exactly one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Input sample strobe |
| smp_i | input | SAMP_W | In-phase sample (bit 0 only in 1-bit format) |
| smp_q | input | SAMP_W | Quadrature sample (bit 0 only in 1-bit format) |
| corr_valid | output | 1 | One-cycle result strobe |
| corr_mag | output | 2*ACC_W+1 | Correlation magnitude, with ACC_W = SAMP_W+COEF_W+1+log2(TAPS) |
| overrun | output | 1 | Sticky flag: a sample arrived during a slot |

## Verification
Two things can happen in the same cycle. The result of one slot can be registered while the next sample is accepted and its tap 0 is multiplied. Separately, an overrun can coincide with the final tap of a slot.

The stimulus provokes both. It sends long runs of samples spaced exactly 64 cycles apart. It also places one strobe 10 cycles into a slot and another in the slot's last cycle. A behavioural model in the bench keeps a queue of accepted samples and compares both the strobe and the magnitude on every clock. The check after an overrun passes only if the dropped sample never reached the delay line.

// File: rtl/cmf_pkg.sv
package cmf_pkg;

    typedef enum logic {
        S_IDLE,
        S_RUN
    } cmf_state_e;

    function automatic int acc_width(input int samp_w, input int coef_w, input int taps);
        return samp_w + coef_w + 1 + $clog2(taps);
    endfunction

endpackage

// File: rtl/cmf_coef_rom.sv
module cmf_coef_rom #(
    parameter int TAPS   = 64,
    parameter int COEF_W = 4,
    localparam int IDX_W = $clog2(TAPS)
) (
    input  logic [IDX_W-1:0]         idx,
    output logic signed [COEF_W-1:0] c_re,
    output logic signed [COEF_W-1:0] c_im
);

    logic signed [COEF_W-1:0] tbl_re [TAPS];
    logic signed [COEF_W-1:0] tbl_im [TAPS];

    // Conjugated reference values, computed per entry
    for (genvar k = 0; k < TAPS; k++) begin : g_entry
        assign tbl_re[k] = COEF_W'(((5 * k + 3) % 15) - 7);
        assign tbl_im[k] = COEF_W'(((11 * k + 6) % 15) - 7);
    end

    assign c_re = tbl_re[idx];
    assign c_im = tbl_im[idx];

endmodule

// File: rtl/cmf_delay_line.sv
module cmf_delay_line #(
    parameter int DEPTH  = 64,
    parameter int ELEM_W = 10,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ELEM_W-1:0] wr_re,
    input  logic [ELEM_W-1:0] wr_im,
    input  logic [PTR_W-1:0]  rd_age,
    output logic [ELEM_W-1:0] rd_re,
    output logic [ELEM_W-1:0] rd_im
);

    logic [ELEM_W-1:0] mem_re [DEPTH];
    logic [ELEM_W-1:0] mem_im [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_re[i] <= '0;
                mem_im[i] <= '0;
            end
        end else if (wr_en) begin
            mem_re[wr_ptr] <= wr_re;
            mem_im[wr_ptr] <= wr_im;
            wr_ptr         <= wr_ptr + 1'b1;
        end
    end

    // Newest entry sits at wr_ptr-1; age counts back from it (wraps on power-of-two depth)
    assign rd_idx = wr_ptr - PTR_W'(1) - rd_age;
    assign rd_re  = mem_re[rd_idx];
    assign rd_im  = mem_im[rd_idx];

endmodule

// File: rtl/cmf_cmac.sv
module cmf_cmac #(
    parameter int ELEM_W  = 10,
    parameter int COEF_W  = 4,
    parameter int ACC_W   = 21,
    parameter bit ONE_BIT = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     first,
    input  logic [ELEM_W-1:0]        x_re,
    input  logic [ELEM_W-1:0]        x_im,
    input  logic signed [COEF_W-1:0] c_re,
    input  logic signed [COEF_W-1:0] c_im,
    output logic signed [ACC_W-1:0]  sum_re,
    output logic signed [ACC_W-1:0]  sum_im
);

    logic signed [ACC_W-1:0] cr_e, ci_e;
    logic signed [ACC_W-1:0] prod_re, prod_im;
    logic signed [ACC_W-1:0] acc_re, acc_im;

    assign cr_e = ACC_W'(c_re);
    assign ci_e = ACC_W'(c_im);

    if (ONE_BIT) begin : g_sign
        // Sample parts are +1 (code 0) or -1 (code 1): add or subtract coefficient parts
        assign prod_re = (x_re[0] ? -cr_e : cr_e) - (x_im[0] ? -ci_e : ci_e);
        assign prod_im = (x_re[0] ? -ci_e : ci_e) + (x_im[0] ? -cr_e : cr_e);
    end else begin : g_mult
        logic signed [ACC_W-1:0] xr_e, xi_e;
        assign xr_e    = ACC_W'($signed(x_re));
        assign xi_e    = ACC_W'($signed(x_im));
        assign prod_re = xr_e * cr_e - xi_e * ci_e;
        assign prod_im = xr_e * ci_e + xi_e * cr_e;
    end

    assign sum_re = first ? prod_re : acc_re + prod_re;
    assign sum_im = first ? prod_im : acc_im + prod_im;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_re <= '0;
            acc_im <= '0;
        end else if (en) begin
            acc_re <= sum_re;
            acc_im <= sum_im;
        end
    end

endmodule

// File: rtl/cmf_magnitude.sv
module cmf_magnitude #(
    parameter int ACC_W  = 21,
    parameter bit MAG_SQ = 1'b1,
    localparam int MAG_W = 2 * ACC_W + 1
) (
    input  logic signed [ACC_W-1:0] v_re,
    input  logic signed [ACC_W-1:0] v_im,
    output logic [MAG_W-1:0]        mag
);

    logic signed [MAG_W-1:0] re_w, im_w;

    assign re_w = MAG_W'(v_re);
    assign im_w = MAG_W'(v_im);

    if (MAG_SQ) begin : g_square
        assign mag = MAG_W'(re_w * re_w + im_w * im_w);
    end else begin : g_abs
        logic signed [MAG_W-1:0] re_a, im_a;
        assign re_a = (re_w < 0) ? -re_w : re_w;
        assign im_a = (im_w < 0) ? -im_w : im_w;
        assign mag  = MAG_W'(re_a + im_a);
    end

endmodule

// File: rtl/corr_serial_mf.sv
module corr_serial_mf
    import cmf_pkg::*;
#(
    parameter int SAMP_W  = 10,
    parameter int COEF_W  = 4,
    parameter int TAPS    = 64,
    parameter bit ONE_BIT = 1'b0,
    parameter bit MAG_SQ  = 1'b1
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic                                           smp_valid,
    input  logic [SAMP_W-1:0]                              smp_i,
    input  logic [SAMP_W-1:0]                              smp_q,
    output logic                                           corr_valid,
    output logic [2*acc_width(SAMP_W, COEF_W, TAPS):0]     corr_mag,
    output logic                                           overrun
);

    localparam int TAP_W  = $clog2(TAPS);
    localparam int ELEM_W = ONE_BIT ? 1 : SAMP_W;
    localparam int ACC_W  = acc_width(SAMP_W, COEF_W, TAPS);
    localparam int MAG_W  = 2 * ACC_W + 1;
    localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(TAPS - 1);

    cmf_state_e state_q, state_d;
    logic [TAP_W-1:0] tap_q, tap_d;

    logic accept, run_flag, last_tap, collide, mac_en;
    logic [ELEM_W-1:0] new_re, new_im, old_re, old_im, x_re, x_im;
    logic signed [COEF_W-1:0] c_re, c_im;
    logic signed [ACC_W-1:0]  sum_re, sum_im;
    logic [MAG_W-1:0] mag_now;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            tap_q   <= '0;
        end else begin
            state_q <= state_d;
            tap_q   <= tap_d;
        end
    end

    // Next state: T_IDLE_HOLD, T_ACCEPT, T_STEP, T_FINISH
    always_comb begin
        state_d = state_q;
        tap_d   = tap_q;
        unique case (state_q)
            S_IDLE: begin
                if (smp_valid) begin
                    state_d = S_RUN;
                    tap_d   = TAP_W'(1);
                end
            end
            S_RUN: begin
                if (tap_q == LAST_TAP) begin
                    state_d = S_IDLE;
                    tap_d   = '0;
                end else begin
                    tap_d = tap_q + 1'b1;
                end
            end
            default: begin
                state_d = S_IDLE;
                tap_d   = '0;
            end
        endcase
    end

    // Decoded controls
    always_comb begin
        run_flag = (state_q == S_RUN);
        accept   = (state_q == S_IDLE) && smp_valid;
        last_tap = run_flag && (tap_q == LAST_TAP);
        collide  = run_flag && smp_valid;
        mac_en   = accept || run_flag;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_valid <= 1'b0;
            corr_mag   <= '0;
            overrun    <= 1'b0;
        end else begin
            corr_valid <= last_tap;
            if (last_tap) begin
                corr_mag <= mag_now;
            end
            if (collide) begin
                overrun <= 1'b1;
            end
        end
    end

    assign new_re = ELEM_W'(smp_i);
    assign new_im = ELEM_W'(smp_q);
    // Tap 0 uses the incoming sample directly, the rest come from the buffer
    assign x_re = accept ? new_re : old_re;
    assign x_im = accept ? new_im : old_im;

    cmf_delay_line #(
        .DEPTH (TAPS),
        .ELEM_W(ELEM_W)
    ) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (accept),
        .wr_re (new_re),
        .wr_im (new_im),
        .rd_age(tap_q),
        .rd_re (old_re),
        .rd_im (old_im)
    );

    cmf_coef_rom #(
        .TAPS  (TAPS),
        .COEF_W(COEF_W)
    ) u_rom (
        .idx (tap_q),
        .c_re(c_re),
        .c_im(c_im)
    );

    cmf_cmac #(
        .ELEM_W (ELEM_W),
        .COEF_W (COEF_W),
        .ACC_W  (ACC_W),
        .ONE_BIT(ONE_BIT)
    ) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (mac_en),
        .first (accept),
        .x_re  (x_re),
        .x_im  (x_im),
        .c_re  (c_re),
        .c_im  (c_im),
        .sum_re(sum_re),
        .sum_im(sum_im)
    );

    cmf_magnitude #(
        .ACC_W (ACC_W),
        .MAG_SQ(MAG_SQ)
    ) u_mag (
        .v_re(sum_re),
        .v_im(sum_im),
        .mag (mag_now)
    );

endmodule

// File: rtl/cmf_checker.sv
module cmf_checker #(
    parameter int TAP_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic             run_flag,
    input logic [TAP_W-1:0] tap,
    input logic             corr_valid,
    input logic             overrun
);

    p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |=> !corr_valid);

    p_result_after_last_tap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |-> ($past(run_flag) && $past(tap) == {TAP_W{1'b1}}));

    p_run_tap_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        run_flag |-> (tap != '0));

    p_collide_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && run_flag) |=> overrun);

    p_flag_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(smp_valid && run_flag));

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

bind corr_serial_mf cmf_checker #(.TAP_W(TAP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .run_flag  (run_flag),
    .tap       (tap_q),
    .corr_valid(corr_valid),
    .overrun   (overrun)
);

// File: tb/tb_corr_serial_mf.sv
module tb_corr_serial_mf;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic [9:0] smp_i = '0, smp_q = '0;
    logic cv_a, ov_a, cv_b, ov_b;
    logic [42:0] mag_a, mag_b;

    corr_serial_mf dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
        .corr_valid(cv_a), .corr_mag(mag_a), .overrun(ov_a));

    corr_serial_mf #(.ONE_BIT(1'b1), .MAG_SQ(1'b0)) dut_b (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
        .corr_valid(cv_b), .corr_mag(mag_b), .overrun(ov_b));

    int checks = 0, fails = 0, cyc = 0, free_at = 0;
    bit done = 1'b0, exp_ovr = 1'b0;
    string tag = "R1";
    int hist_i[$], hist_q[$], due_q[$];
    longint ma_q[$], mb_q[$];

    function automatic int cre(int k); return ((5 * k + 3) % 15) - 7; endfunction
    function automatic int cim(int k); return ((11 * k + 6) % 15) - 7; endfunction

    function automatic int interp(int mode, int raw);
        if (mode == 0) return (raw >= 512) ? raw - 1024 : raw;
        return (raw % 2 == 1) ? -1 : 1;
    endfunction

    function automatic longint expect_mag(int mode);
        longint sr = 0, si = 0;
        for (int k = 0; k < 64; k++) begin
            longint xr = interp(mode, hist_i[k]);
            longint xi = interp(mode, hist_q[k]);
            sr += xr * cre(k) - xi * cim(k);
            si += xr * cim(k) + xi * cre(k);
        end
        if (mode == 0) return sr * sr + si * si;
        return ((sr < 0) ? -sr : sr) + ((si < 0) ? -si : si);
    endfunction

    task automatic chk(bit ok, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s [%s] actual=%0d expected=%0d at cycle %0d", what, tag, act, exp, cyc);
        end
    endtask

    // Behavioural model: accepted samples and scheduled results
    always @(posedge clk) begin
        cyc++;
        if (rst_n && smp_valid) begin
            if (cyc >= free_at) begin
                hist_i.push_front(int'(smp_i));
                hist_q.push_front(int'(smp_q));
                void'(hist_i.pop_back());
                void'(hist_q.pop_back());
                due_q.push_back(cyc + 63);
                ma_q.push_back(expect_mag(0));
                mb_q.push_back(expect_mag(1));
                free_at = cyc + 64;
            end else begin
                exp_ovr = 1'b1;
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ev;
            ev = (due_q.size() > 0) && (due_q[0] == cyc);
            chk(cv_a == ev, "R3 R10 R7 valid strobe (multi-bit)", cv_a, ev);
            chk(cv_b == ev, "R3 R10 R7 valid strobe (1-bit)", cv_b, ev);
            if (ev) begin
                chk(mag_a == ma_q[0], "R2 R4 R6 magnitude (multi-bit, squared)", mag_a, ma_q[0]);
                chk(mag_b == mb_q[0], "R2 R5 R6 magnitude (1-bit, abs sum)", mag_b, mb_q[0]);
                void'(due_q.pop_front());
                void'(ma_q.pop_front());
                void'(mb_q.pop_front());
            end
            chk(ov_a == exp_ovr, "R8 R9 overrun (multi-bit)", ov_a, exp_ovr);
            chk(ov_b == exp_ovr, "R8 R9 overrun (1-bit)", ov_b, exp_ovr);
        end
    end

    task automatic send(int vi, int vq, int gap);
        smp_i = 10'(vi);
        smp_q = 10'(vq);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        for (int k = 0; k < 64; k++) begin
            hist_i.push_back(0);
            hist_q.push_back(0);
        end
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(cv_a == 1'b0 && cv_b == 1'b0, "R1 valid low in reset", cv_a | cv_b, 0);
        chk(ov_a == 1'b0 && ov_b == 1'b0, "R1 overrun low in reset", ov_a | ov_b, 0);
        chk(mag_a == 0 && mag_b == 0, "R1 magnitude zero in reset", mag_a | mag_b, 0);
        rst_n = 1'b1;

        // R7: back-to-back random samples at exactly 64-cycle spacing
        tag = "R7";
        for (int n = 0; n < 40; n++) send($urandom_range(0, 1023), $urandom_range(0, 1023), 64);

        // R2: embedded conjugate copy of the reference, then random tail, varied spacing
        tag = "R2";
        for (int k = 63; k >= 0; k--) send(cre(k) * 60, -cim(k) * 60, 64 + (k % 3));
        for (int n = 0; n < 20; n++) send($urandom_range(0, 1023), $urandom_range(0, 1023), 66);

        // R4 R5: full-scale and sign-boundary codes
        tag = "R4 R5";
        for (int n = 0; n < 70; n++) begin
            int pick_i = n % 4, pick_q = (n / 2) % 4;
            int vi = (pick_i == 0) ? 511 : (pick_i == 1) ? 512 : (pick_i == 2) ? 512 : 1;
            int vq = (pick_q == 0) ? 512 : (pick_q == 1) ? 511 : (pick_q == 2) ? 0 : 512;
            send(vi, vq, 64);
        end

        // R8: strobes inside a slot are dropped (mid-slot and on the final tap)
        tag = "R8";
        send(100, -200, 10);
        send(511, 511, 64);
        send(-50, 75, 63);
        send(-512, -512, 64);
        for (int n = 0; n < 20; n++) send($urandom_range(0, 1023), $urandom_range(0, 1023), 64);

        // R9: flag stays set across further traffic
        tag = "R9";
        for (int n = 0; n < 10; n++) send($urandom_range(0, 1023), $urandom_range(0, 1023), 65);
        repeat (80) @(negedge clk);
        chk(due_q.size() == 0, "R10 every accepted sample produced a result", due_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog [%s] actual=%0d expected=%0d", tag, cyc, 0);
            summary();
            $finish;
        end
    end

endmodule